// File: doc/BRIEF.md
# Dual-Issue In-Order Pairing Checker

This block is the pairing decision of a two-wide in-order issue stage. In every clock cycle it examines the two oldest decoded instructions waiting in the instruction buffer. The older one is called slot A and the younger one slot B. It then decides whether both go to the two execution pipes, only slot A goes, or nothing goes. Each slot presents:

- a valid bit;
- two source register indices, each with its own use bit;
- one destination index with a write bit.

A scoreboard vector marks registers that instructions already in flight have yet to write. The block never reorders instructions. When slot B depends on slot A, pipe 2 stays empty for that cycle, and slot B becomes the older instruction in a later cycle.

The decision is registered in a small state machine whose state is the issue class of the current cycle. There are four states: `ISS_IDLE` (slot A empty), `ISS_HOLD` (slot A waits on a busy source), `ISS_SINGLE` (only slot A issues) and `ISS_DUAL` (both issue). Every state can move to every state at each clock edge. The next state is chosen by priority from the inputs:

- the move to `ISS_IDLE` is taken when slot A is invalid;
- otherwise, the move to `ISS_HOLD` is taken when slot A reads a busy register;
- otherwise, the move to `ISS_SINGLE` is taken when slot B is invalid, has a read-after-write or write-after-write hazard on slot A, or reads a busy register;
- otherwise, the move to `ISS_DUAL` is taken.

Reset forces `ISS_IDLE`. The issue enables and the consumed count are decoded from the state. The buffer uses the consumed count to pop 0, 1 or 2 entries.

Top module: `dual_issue_pairer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, issue_p1, issue_p2 and consume_cnt are all 0.
- R2: issue_p2 is never 1 unless issue_p1 is 1 in the same cycle, so slot B never issues ahead of or without slot A.
- R3: consume_cnt equals the number of asserted issue enables: 0, 1 or 2 (encoded as a 2-bit binary number).
- R4: When a_vld is 0, neither pipe issues.
- R5: When slot A is valid and either of its enabled sources indexes a register whose reg_busy bit is 1, neither pipe issues; a source whose enable bit is 0 is not looked up.
- R6: When b_vld is 0 and slot A can issue, only pipe 1 issues, whatever slot B's register fields hold.
- R7: Read-after-write: when an enabled source of slot B equals slot A's destination and a_dst_en is 1, only pipe 1 issues; with a_dst_en at 0 there is no hazard.
- R8: Write-after-write: when both destination enables are 1 and the two destination indices are equal, only pipe 1 issues.
- R9: Write-after-read (slot B writes a register that slot A reads) does not prevent dual issue.
- R10: When an enabled source of slot B indexes a busy register, only pipe 1 issues.
- R11: A valid, mutually independent pair with no busy source issues on both pipes (consume_cnt = 2).
- R12: The decision for the inputs present at a rising edge is shown on the outputs from that edge until the next one, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld | input | 1 | Older slot holds an instruction |
| a_src0 | input | IDX_W | Older slot first source index |
| a_src0_en | input | 1 | Older slot first source is read |
| a_src1 | input | IDX_W | Older slot second source index |
| a_src1_en | input | 1 | Older slot second source is read |
| a_dst | input | IDX_W | Older slot destination index |
| a_dst_en | input | 1 | Older slot writes its destination |
| b_vld | input | 1 | Younger slot holds an instruction |
| b_src0 | input | IDX_W | Younger slot first source index |
| b_src0_en | input | 1 | Younger slot first source is read |
| b_src1 | input | IDX_W | Younger slot second source index |
| b_src1_en | input | 1 | Younger slot second source is read |
| b_dst | input | IDX_W | Younger slot destination index |
| b_dst_en | input | 1 | Younger slot writes its destination |
| reg_busy | input | 2**IDX_W | One bit per register, 1 while an in-flight write is pending |
| issue_p1 | output | 1 | Older instruction goes to pipe 1 |
| issue_p2 | output | 1 | Younger instruction goes to pipe 2 |
| consume_cnt | output | 2 | Entries to pop from the instruction buffer |

## Verification
A wrong state shows at the ports one cycle after the inputs that caused it, and it persists for a single cycle only, because the state is rebuilt from the inputs at every edge. A missed hazard appears as issue_p2 high where one pipe was due. A missed busy source appears as issue_p1 high during a hold. A corrupted state encoding shows as consume_cnt disagreeing with the enables, or as pipe 2 without pipe 1. Each stimulus is therefore checked at the one cycle that follows it, and consecutive stimuli switch between states so that every transition is exercised.

// File: rtl/dip_pkg.sv
package dip_pkg;

    typedef enum logic [1:0] {
        ISS_IDLE   = 2'd0,
        ISS_HOLD   = 2'd1,
        ISS_SINGLE = 2'd2,
        ISS_DUAL   = 2'd3
    } iss_state_e;

endpackage

// File: rtl/dip_busy_probe.sv
module dip_busy_probe #(
    parameter int IDX_W = 5,
    localparam int NREG = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] src0,
    input  logic             src0_en,
    input  logic [IDX_W-1:0] src1,
    input  logic             src1_en,
    input  logic [NREG-1:0]  busy,
    output logic             hit
);

    logic hit0;
    logic hit1;

    always_comb begin
        hit0 = src0_en && busy[src0];
        hit1 = src1_en && busy[src1];
        hit  = hit0 || hit1;
    end

endmodule

// File: rtl/dip_pair_hazard.sv
module dip_pair_hazard #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] old_dst,
    input  logic             old_dst_en,
    input  logic [IDX_W-1:0] yng_src0,
    input  logic             yng_src0_en,
    input  logic [IDX_W-1:0] yng_src1,
    input  logic             yng_src1_en,
    input  logic [IDX_W-1:0] yng_dst,
    input  logic             yng_dst_en,
    output logic             raw,
    output logic             waw
);

    logic raw0;
    logic raw1;

    always_comb begin
        raw0 = old_dst_en && yng_src0_en && (yng_src0 == old_dst);
        raw1 = old_dst_en && yng_src1_en && (yng_src1 == old_dst);
        raw  = raw0 || raw1;
        // no renaming, so a shared destination must serialise
        waw  = old_dst_en && yng_dst_en && (yng_dst == old_dst);
    end

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
    import dip_pkg::*;
#(
    parameter int IDX_W = 5,
    localparam int NREG = 1 << IDX_W,
    localparam int NSLOT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_vld,
    input  logic [IDX_W-1:0] a_src0,
    input  logic             a_src0_en,
    input  logic [IDX_W-1:0] a_src1,
    input  logic             a_src1_en,
    input  logic [IDX_W-1:0] a_dst,
    input  logic             a_dst_en,
    input  logic             b_vld,
    input  logic [IDX_W-1:0] b_src0,
    input  logic             b_src0_en,
    input  logic [IDX_W-1:0] b_src1,
    input  logic             b_src1_en,
    input  logic [IDX_W-1:0] b_dst,
    input  logic             b_dst_en,
    input  logic [NREG-1:0]  reg_busy,
    output logic             issue_p1,
    output logic             issue_p2,
    output logic [1:0]       consume_cnt
);

    // slot 0 is the older instruction, slot 1 the younger
    logic [IDX_W-1:0] s_src0    [NSLOT];
    logic             s_src0_en [NSLOT];
    logic [IDX_W-1:0] s_src1    [NSLOT];
    logic             s_src1_en [NSLOT];
    logic [NSLOT-1:0] s_busy_hit;

    always_comb begin
        s_src0[0]    = a_src0;
        s_src0_en[0] = a_src0_en;
        s_src1[0]    = a_src1;
        s_src1_en[0] = a_src1_en;
        s_src0[1]    = b_src0;
        s_src0_en[1] = b_src0_en;
        s_src1[1]    = b_src1;
        s_src1_en[1] = b_src1_en;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_probe
        dip_busy_probe #(.IDX_W(IDX_W)) u_probe (
            .src0    (s_src0[g]),
            .src0_en (s_src0_en[g]),
            .src1    (s_src1[g]),
            .src1_en (s_src1_en[g]),
            .busy    (reg_busy),
            .hit     (s_busy_hit[g])
        );
    end

    logic pair_raw;
    logic pair_waw;

    dip_pair_hazard #(.IDX_W(IDX_W)) u_hazard (
        .old_dst     (a_dst),
        .old_dst_en  (a_dst_en),
        .yng_src0    (b_src0),
        .yng_src0_en (b_src0_en),
        .yng_src1    (b_src1),
        .yng_src1_en (b_src1_en),
        .yng_dst     (b_dst),
        .yng_dst_en  (b_dst_en),
        .raw         (pair_raw),
        .waw         (pair_waw)
    );

    iss_state_e state_q;
    iss_state_e state_d;
    logic       yng_blocked;

    always_comb begin
        yng_blocked = !b_vld || pair_raw || pair_waw || s_busy_hit[1];
        if (!a_vld) begin
            state_d = ISS_IDLE;
        end else if (s_busy_hit[0]) begin
            state_d = ISS_HOLD;
        end else if (yng_blocked) begin
            state_d = ISS_SINGLE;
        end else begin
            state_d = ISS_DUAL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ISS_IDLE: begin
                issue_p1    = 1'b0;
                issue_p2    = 1'b0;
                consume_cnt = 2'd0;
            end
            ISS_HOLD: begin
                issue_p1    = 1'b0;
                issue_p2    = 1'b0;
                consume_cnt = 2'd0;
            end
            ISS_SINGLE: begin
                issue_p1    = 1'b1;
                issue_p2    = 1'b0;
                consume_cnt = 2'd1;
            end
            ISS_DUAL: begin
                issue_p1    = 1'b1;
                issue_p2    = 1'b1;
                consume_cnt = 2'd2;
            end
            default: begin
                issue_p1    = 1'b0;
                issue_p2    = 1'b0;
                consume_cnt = 2'd0;
            end
        endcase
    end

    // R1: outputs are quiet in the cycle after a reset cycle
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!issue_p1 && !issue_p2 && consume_cnt == 2'd0));

    assert_in_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_p2 |-> issue_p1);

    assert_count_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        consume_cnt == 2'($countones({issue_p1, issue_p2})));

    assert_empty_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !a_vld |=> !issue_p1);

    assert_busy_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_vld && s_busy_hit[0]) |=> !issue_p1);

    assert_young_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !b_vld |=> !issue_p2);

    assert_raw_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pair_raw |=> !issue_p2);

    assert_waw_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pair_waw |=> !issue_p2);

    assert_young_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_busy_hit[1] |=> !issue_p2);

endmodule

// File: tb/test_dual_issue_pairer.sv
module test_dual_issue_pairer;

    localparam int IDX_W = 5;
    localparam int NREG  = 1 << IDX_W;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] s0;
        logic             s0e;
        logic [IDX_W-1:0] s1;
        logic             s1e;
        logic [IDX_W-1:0] d;
        logic             de;
    } slot_t;

    typedef struct {
        logic [1:0] cnt;
        string      req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    slot_t            sa = '0;
    slot_t            sb = '0;
    logic [NREG-1:0]  busy = '0;
    logic             issue_p1;
    logic             issue_p2;
    logic [1:0]       consume_cnt;

    int checks = 0;
    int fails  = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    dual_issue_pairer #(.IDX_W(IDX_W)) i_dual_issue_pairer (
        .clk(clk), .rst_n(rst_n),
        .a_vld(sa.vld), .a_src0(sa.s0), .a_src0_en(sa.s0e),
        .a_src1(sa.s1), .a_src1_en(sa.s1e), .a_dst(sa.d), .a_dst_en(sa.de),
        .b_vld(sb.vld), .b_src0(sb.s0), .b_src0_en(sb.s0e),
        .b_src1(sb.s1), .b_src1_en(sb.s1e), .b_dst(sb.d), .b_dst_en(sb.de),
        .reg_busy(busy),
        .issue_p1(issue_p1), .issue_p2(issue_p2), .consume_cnt(consume_cnt)
    );

    function automatic slot_t mk(logic v, int s0, logic s0e, int s1, logic s1e,
                                 int d, logic de);
        slot_t s;
        s.vld = v;
        s.s0 = IDX_W'(s0); s.s0e = s0e;
        s.s1 = IDX_W'(s1); s.s1e = s1e;
        s.d  = IDX_W'(d);  s.de  = de;
        return s;
    endfunction

    // expected entry count from the requirements
    function automatic logic [1:0] model(slot_t o, slot_t y, logic [NREG-1:0] bz);
        logic rd_busy_o, rd_busy_y, raw, waw;
        if (!o.vld) return 2'd0;
        rd_busy_o = (o.s0e && bz[o.s0]) || (o.s1e && bz[o.s1]);
        if (rd_busy_o) return 2'd0;
        if (!y.vld) return 2'd1;
        rd_busy_y = (y.s0e && bz[y.s0]) || (y.s1e && bz[y.s1]);
        raw = o.de && ((y.s0e && y.s0 == o.d) || (y.s1e && y.s1 == o.d));
        waw = o.de && y.de && (y.d == o.d);
        if (rd_busy_y || raw || waw) return 2'd1;
        return 2'd2;
    endfunction

    task automatic drive(slot_t o, slot_t y, logic [NREG-1:0] bz, string req);
        exp_t e;
        @(negedge clk);
        sa = o; sb = y; busy = bz;
        e.cnt = model(o, y, bz);
        e.req = req;
        q.push_back(e);
    endtask

    // monitor: 5 ns after each rising edge, check the decision for the
    // inputs driven before that edge (R12 one-cycle latency)
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                logic [1:0] got;
                e = q.pop_front();
                got = 2'(issue_p1) + 2'(issue_p2);
                checks++;
                if ({issue_p1, issue_p2} !== {e.cnt != 0, e.cnt == 2}) begin
                    fails++;
                    $display("FAIL %s (R12 latency): p1=%0b p2=%0b expected p1=%0b p2=%0b",
                             e.req, issue_p1, issue_p2, e.cnt != 0, e.cnt == 2);
                end
                checks++;
                if (consume_cnt !== e.cnt || consume_cnt !== got) begin
                    fails++;
                    $display("FAIL R3 count (%s): consume_cnt=%0d expected %0d",
                             e.req, consume_cnt, e.cnt);
                end
                checks++;
                if (issue_p2 && !issue_p1) begin
                    fails++;
                    $display("FAIL R2 order (%s): p1=%0b p2=%0b expected p2 only with p1",
                             e.req, issue_p1, issue_p2);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [NREG-1:0] bz;
        // independent pair driven during reset: outputs must stay quiet (R1)
        sa = mk(1, 1, 1, 2, 1, 3, 1);
        sb = mk(1, 4, 1, 5, 1, 6, 1);
        repeat (3) @(posedge clk);
        #5;
        checks++;
        if ({issue_p1, issue_p2, consume_cnt} !== 4'b0) begin
            fails++;
            $display("FAIL R1 reset: p1=%0b p2=%0b cnt=%0d expected 0 0 0",
                     issue_p1, issue_p2, consume_cnt);
        end
        @(negedge clk);
        rst_n = 1'b1;
        sa = '0; sb = '0;
        @(posedge clk);
        #5;
        checks++;
        if ({issue_p1, issue_p2, consume_cnt} !== 4'b0) begin
            fails++;
            $display("FAIL R1 first cycle: p1=%0b p2=%0b cnt=%0d expected 0 0 0",
                     issue_p1, issue_p2, consume_cnt);
        end

        drive(mk(1, 1, 1, 2, 1, 3, 1), mk(1, 4, 1, 5, 1, 6, 1), '0, "R11 independent pair");
        drive(mk(0, 1, 1, 2, 1, 3, 1), mk(1, 4, 1, 5, 1, 6, 1), '0, "R4 older invalid");
        drive(mk(1, 1, 1, 2, 1, 7, 1), mk(1, 7, 1, 5, 1, 6, 1), '0, "R7 raw on src0");
        drive(mk(1, 1, 1, 2, 1, 7, 1), mk(1, 4, 1, 7, 1, 6, 1), '0, "R7 raw on src1");
        drive(mk(1, 1, 1, 2, 1, 7, 0), mk(1, 7, 1, 7, 1, 6, 1), '0, "R7 no write no hazard");
        drive(mk(1, 1, 1, 2, 1, 7, 1), mk(1, 7, 0, 4, 1, 6, 1), '0, "R7 unused source");
        drive(mk(1, 1, 1, 2, 1, 9, 1), mk(1, 4, 1, 5, 1, 9, 1), '0, "R8 waw");
        drive(mk(1, 1, 1, 2, 1, 9, 1), mk(1, 4, 1, 5, 0, 9, 0), '0, "R8 younger no write");
        drive(mk(1, 11, 1, 12, 1, 3, 1), mk(1, 4, 1, 5, 1, 11, 1), '0, "R9 war dual");
        bz = '0; bz[12] = 1'b1;
        drive(mk(1, 11, 1, 12, 1, 3, 1), mk(1, 4, 1, 5, 1, 6, 1), bz, "R5 older src busy");
        drive(mk(1, 11, 1, 12, 0, 3, 1), mk(1, 4, 1, 5, 1, 6, 1), bz, "R5 unused source busy");
        drive(mk(1, 12, 1, 2, 1, 3, 1), mk(0, 12, 1, 3, 1, 3, 1), bz, "R5 hold with younger empty");
        drive(mk(1, 1, 1, 2, 1, 3, 1), mk(0, 3, 1, 3, 1, 3, 1), '0, "R6 younger invalid");
        drive(mk(1, 1, 1, 2, 1, 3, 1), mk(1, 4, 1, 12, 1, 6, 1), bz, "R10 younger src busy");
        drive(mk(1, 1, 1, 2, 1, 3, 1), mk(1, 4, 1, 12, 0, 6, 1), bz, "R10 unused younger busy");
        drive(mk(1, 0, 1, 31, 1, 31, 1), mk(1, 30, 1, 29, 1, 0, 1), '0, "R11 edge indices");
        bz = '1;
        drive(mk(1, 1, 0, 2, 0, 3, 1), mk(1, 4, 0, 5, 0, 6, 1), bz, "R11 no sources all busy");
        drive(mk(0, 0, 0, 0, 0, 0, 0), mk(0, 0, 0, 0, 0, 0, 0), '0, "R4 empty pair");
        @(negedge clk);
        sa = '0; sb = '0;
        repeat (3) @(posedge clk);
        #6;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule